// File: doc/BRIEF.md
# Shifter Operand Unit with Carry

This block is the combinational operand stage that sits ahead of the ALU in a 32-bit RISC datapath. It works out a shift operation and an effective amount from one of three sources, then shifts or rotates the operand. It returns the shifted value, the carry produced by the shift, and a flag that marks a request the shifter cannot carry out.

The first source is an instruction word. The block pulls a 2-bit shift type and a 5-bit amount from one of two field layouts. A zero amount is then reinterpreted according to the type. The second source is a register: a 2-bit type plus the low byte of a register value, so amounts from 0 to 255 reach the shifter. The third source is an explicit operation code plus that same low byte. Flag storage, the ALU and instruction fetch lie outside the block.

The decoded operation and amount are also driven out on ports. A neighbouring stage can use them, and they make the decode visible for checking.

Top module: `sop_shifter_unit`

## Requirements
- R1: With `src_sel`=0 and `layout_alt`=0, the shift type is taken from `instr_word[6:5]` and the 5-bit amount field from `instr_word[11:7]`.
- R2: With `src_sel`=0 and `layout_alt`=1, the shift type is taken from `instr_word[5:4]` and the amount field is `{instr_word[14:12], instr_word[7:6]}`.
- R3: In the instruction-word source, `shift_kind` uses the codes LSL=0, LSR=1, ASR=2, ROR=3 and RRX=4. Type 0 gives LSL with the field as the amount. Types 1 and 2 give LSR and ASR, and a zero field means an amount of 32 for both.
- R4: In the instruction-word source, type 3 with a zero field gives RRX with amount 1. Type 3 with a nonzero field gives ROR by the field.
- R5: With `src_sel`=1, `reg_type` 0..3 maps to LSL, LSR, ASR and ROR, and never to RRX. The amount is `reg_value[7:0]`, and bits 31:8 of `reg_value` have no effect on any output.
- R6: With `src_sel`=2 or 3, `shift_kind` equals `direct_op` and the amount is `reg_value[7:0]`.
- R7: For a valid operation other than RRX with amount 0, `result` equals `value_in` and `carry_out` equals `carry_in`.
- R8: LSL by n≥1 gives `value_in<<n`, which is 0 when n≥32. Its carry is bit 32−n of the input for n≤32 and 0 for n>32.
- R9: LSR by n≥1 gives a zero-filled right shift, which is 0 when n≥32. Its carry is input bit n−1 for n≤32 and 0 for n>32.
- R10: ASR by n≥1 fills with the sign bit and its carry is input bit n−1. For n≥32 the result is all sign bits and the carry is the sign bit.
- R11: ROR by n≥1 rotates right by n mod 32, and its carry is bit 31 of the rotated result.
- R12: RRX with amount 1 gives `{carry_in, value_in[31:1]}`, and its carry is `value_in[0]`.
- R13: RRX with any amount other than 1, or a `shift_kind` of 5, 6 or 7, sets `invalid`=1 and forces `result`=0 and `carry_out`=0. Otherwise `invalid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_word | input | 32 | Instruction word holding the shift fields |
| layout_alt | input | 1 | 0 selects the first field layout, 1 the second |
| src_sel | input | 2 | 0 instruction word, 1 register type and amount, 2/3 explicit operation |
| reg_type | input | 2 | Shift type for the register source |
| reg_value | input | 32 | Register carrying the amount in its low byte |
| direct_op | input | 3 | Operation code for the explicit source |
| value_in | input | 32 | Operand to shift |
| carry_in | input | 1 | Incoming carry flag |
| shift_kind | output | 3 | Decoded operation code |
| shift_amount | output | 8 | Decoded effective amount |
| result | output | 32 | Shifted or rotated operand |
| carry_out | output | 1 | Carry produced by the shift |
| invalid | output | 1 | Request could not be performed |

## Verification
The bench builds the unit with its defaults: a 32-bit datapath and an 8-bit amount. That 8-bit amount lets register and explicit amounts run past the word width, up to 255. It is what brings the over-width carry rules of R8 to R10 and the modulo wrap of R11 within reach, next to the reinterpretation of a zero immediate. The reference model steps the shift one bit at a time, which is a different method from the design's barrel logic.

// File: rtl/sop_pkg.sv
package sop_pkg;

  typedef enum logic [2:0] {
    SK_LSL  = 3'd0,
    SK_LSR  = 3'd1,
    SK_ASR  = 3'd2,
    SK_ROR  = 3'd3,
    SK_RRX  = 3'd4,
    SK_RSV5 = 3'd5,
    SK_RSV6 = 3'd6,
    SK_RSV7 = 3'd7
  } shift_kind_e;

  typedef enum logic [1:0] {
    SRC_IMM   = 2'd0,
    SRC_REG   = 2'd1,
    SRC_DIR_A = 2'd2,
    SRC_DIR_B = 2'd3
  } amt_src_e;

endpackage

// File: rtl/sop_field_extract.sv
module sop_field_extract #(
  parameter int INSTR_W = 32,
  parameter int TYPE_W  = 2,
  parameter int IMM_W   = 5
) (
  input  logic [INSTR_W-1:0] instr,
  input  logic               layout_alt,
  output logic [TYPE_W-1:0]  sh_type,
  output logic [IMM_W-1:0]   sh_imm
);

  // Field positions are fixed by the two instruction layouts.
  localparam int LOW_KEEP = 4;
  localparam int TOP_KEEP = 15;

  logic [TYPE_W-1:0] type_a, type_b;
  logic [IMM_W-1:0]  imm_a, imm_b;

  always_comb begin
    type_a = instr[6:5];
    imm_a  = instr[11:7];
    type_b = instr[5:4];
    imm_b  = {instr[14:12], instr[7:6]};
  end

  assign sh_type = layout_alt ? type_b : type_a;
  assign sh_imm  = layout_alt ? imm_b  : imm_a;

  logic unused_instr_bits;
  assign unused_instr_bits = ^{instr[INSTR_W-1:TOP_KEEP], instr[LOW_KEEP-1:0]};

endmodule

// File: rtl/sop_amount_decode.sv
module sop_amount_decode
  import sop_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8,
  parameter int TYPE_W = 2,
  parameter int IMM_W  = 5
) (
  input  logic [1:0]        src_sel,
  input  logic [TYPE_W-1:0] imm_type,
  input  logic [IMM_W-1:0]  imm_amt,
  input  logic [TYPE_W-1:0] reg_type,
  input  logic [AMT_W-1:0]  reg_amt,
  input  logic [2:0]        direct_op,
  output shift_kind_e       kind,
  output logic [AMT_W-1:0]  amount
);

  localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(DATA_W);
  localparam logic [AMT_W-1:0] ONE_AMT  = AMT_W'(1);

  function automatic shift_kind_e type_to_kind(input logic [TYPE_W-1:0] t);
    case (t)
      2'd0:    return SK_LSL;
      2'd1:    return SK_LSR;
      2'd2:    return SK_ASR;
      default: return SK_ROR;
    endcase
  endfunction

  shift_kind_e      imm_kind;
  logic [AMT_W-1:0] imm_eff;
  logic             imm_zero;

  assign imm_zero = (imm_amt == '0);

  always_comb begin
    imm_kind = type_to_kind(imm_type);
    imm_eff  = AMT_W'(imm_amt);
    case (imm_kind)
      SK_LSR, SK_ASR: if (imm_zero) imm_eff = FULL_AMT;
      SK_ROR: if (imm_zero) begin
        imm_kind = SK_RRX;
        imm_eff  = ONE_AMT;
      end
      default: ;
    endcase
  end

  always_comb begin
    case (amt_src_e'(src_sel))
      SRC_IMM: begin
        kind   = imm_kind;
        amount = imm_eff;
      end
      SRC_REG: begin
        kind   = type_to_kind(reg_type);
        amount = reg_amt;
      end
      default: begin
        kind   = shift_kind_e'(direct_op);
        amount = reg_amt;
      end
    endcase
  end

endmodule

// File: rtl/sop_barrel.sv
module sop_barrel
  import sop_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input  logic [DATA_W-1:0] value,
  input  shift_kind_e       kind,
  input  logic [AMT_W-1:0]  amount,
  input  logic              carry_in,
  output logic [DATA_W-1:0] result,
  output logic              carry_out,
  output logic              bad_req,
  output logic              amt_zero,
  output logic              amt_ge_width
);

  localparam int               LOG_W     = $clog2(DATA_W);
  localparam logic [AMT_W-1:0] WIDTH_AMT = AMT_W'(DATA_W);
  localparam logic [AMT_W-1:0] ONE_AMT   = AMT_W'(1);

  // Right rotator built from power-of-two stages.
  logic [DATA_W-1:0] rot_stage [LOG_W+1];
  logic [LOG_W-1:0]  rot_amt;

  assign rot_amt      = amount[LOG_W-1:0];
  assign rot_stage[0] = value;

  for (genvar gi = 0; gi < LOG_W; gi++) begin : g_rot
    localparam int STEP = 1 << gi;
    assign rot_stage[gi+1] = rot_amt[gi]
      ? {rot_stage[gi][STEP-1:0], rot_stage[gi][DATA_W-1:STEP]}
      : rot_stage[gi];
  end

  // Bit one position before the final one, used for the carry of each shift.
  logic [DATA_W-1:0] left_pre, right_pre;
  logic              sign_bit;

  assign amt_zero     = (amount == '0);
  assign amt_ge_width = (amount >= WIDTH_AMT);
  assign left_pre     = value << (amount - ONE_AMT);
  assign right_pre    = value >> (amount - ONE_AMT);
  assign sign_bit     = value[DATA_W-1];

  function automatic logic [DATA_W-1:0] asr_fill(input logic [DATA_W-1:0] v,
                                                 input logic [AMT_W-1:0]  n);
    return DATA_W'($signed(v) >>> n);
  endfunction

  assign bad_req = ((kind == SK_RRX) && (amount != ONE_AMT)) || (kind > SK_RRX);

  always_comb begin
    result    = '0;
    carry_out = 1'b0;
    if (bad_req) begin
      result    = '0;
      carry_out = 1'b0;
    end else if (amt_zero) begin
      result    = value;
      carry_out = carry_in;
    end else begin
      case (kind)
        SK_LSL: begin
          result    = amt_ge_width ? '0 : (value << amount);
          carry_out = left_pre[DATA_W-1];
        end
        SK_LSR: begin
          result    = amt_ge_width ? '0 : (value >> amount);
          carry_out = right_pre[0];
        end
        SK_ASR: begin
          result    = amt_ge_width ? {DATA_W{sign_bit}} : asr_fill(value, amount);
          carry_out = amt_ge_width ? sign_bit : right_pre[0];
        end
        SK_ROR: begin
          result    = rot_stage[LOG_W];
          carry_out = rot_stage[LOG_W][DATA_W-1];
        end
        SK_RRX: begin
          result    = {carry_in, value[DATA_W-1:1]};
          carry_out = value[0];
        end
        default: begin
          result    = '0;
          carry_out = 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/sop_shifter_unit.sv
module sop_shifter_unit
  import sop_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int INSTR_W = 32,
  parameter int AMT_W   = 8,
  parameter int TYPE_W  = 2,
  parameter int IMM_W   = 5
) (
  input  logic [INSTR_W-1:0] instr_word,
  input  logic               layout_alt,
  input  logic [1:0]         src_sel,
  input  logic [TYPE_W-1:0]  reg_type,
  input  logic [DATA_W-1:0]  reg_value,
  input  logic [2:0]         direct_op,
  input  logic [DATA_W-1:0]  value_in,
  input  logic               carry_in,
  output logic [2:0]         shift_kind,
  output logic [AMT_W-1:0]   shift_amount,
  output logic [DATA_W-1:0]  result,
  output logic               carry_out,
  output logic               invalid
);

  logic [TYPE_W-1:0] ext_type;
  logic [IMM_W-1:0]  ext_imm;
  logic [AMT_W-1:0]  reg_low;
  shift_kind_e       dec_kind;
  logic [AMT_W-1:0]  dec_amt;
  logic              amt_zero;
  logic              amt_ge_width;

  assign reg_low = reg_value[AMT_W-1:0];

  logic unused_reg_high;
  assign unused_reg_high = ^reg_value[DATA_W-1:AMT_W];

  sop_field_extract #(
    .INSTR_W(INSTR_W), .TYPE_W(TYPE_W), .IMM_W(IMM_W)
  ) u_extract (
    .instr      (instr_word),
    .layout_alt (layout_alt),
    .sh_type    (ext_type),
    .sh_imm     (ext_imm)
  );

  sop_amount_decode #(
    .DATA_W(DATA_W), .AMT_W(AMT_W), .TYPE_W(TYPE_W), .IMM_W(IMM_W)
  ) u_decode (
    .src_sel   (src_sel),
    .imm_type  (ext_type),
    .imm_amt   (ext_imm),
    .reg_type  (reg_type),
    .reg_amt   (reg_low),
    .direct_op (direct_op),
    .kind      (dec_kind),
    .amount    (dec_amt)
  );

  sop_barrel #(
    .DATA_W(DATA_W), .AMT_W(AMT_W)
  ) u_barrel (
    .value        (value_in),
    .kind         (dec_kind),
    .amount       (dec_amt),
    .carry_in     (carry_in),
    .result       (result),
    .carry_out    (carry_out),
    .bad_req      (invalid),
    .amt_zero     (amt_zero),
    .amt_ge_width (amt_ge_width)
  );

  assign shift_kind   = dec_kind;
  assign shift_amount = dec_amt;

endmodule

// File: rtl/sop_shifter_checker.sv
module sop_shifter_checker #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input logic [1:0]        src_sel,
  input logic [DATA_W-1:0] value_in,
  input logic              carry_in,
  input logic [2:0]        shift_kind,
  input logic [AMT_W-1:0]  shift_amount,
  input logic [DATA_W-1:0] result,
  input logic              carry_out,
  input logic              invalid,
  input logic              amt_zero,
  input logic              amt_ge_width
);

  localparam logic [AMT_W-1:0] WIDTH_AMT = AMT_W'(DATA_W);

  always_comb begin
    // R13
    if (invalid) invalid_zero_chk: assert (result == '0 && carry_out == 1'b0)
      else $error("invalid request left nonzero outputs");
    // R7
    if (!invalid && amt_zero && shift_kind != 3'd4)
      zero_pass_chk: assert (result == value_in && carry_out == carry_in)
        else $error("zero amount did not pass operand through");
    // R5
    if (src_sel == 2'd1) reg_no_rrx_chk: assert (shift_kind <= 3'd3)
      else $error("register source produced a non-shift code");
    // R4
    if (src_sel == 2'd0 && shift_kind == 3'd4)
      imm_rrx_amt_chk: assert (shift_amount == AMT_W'(1) && !invalid)
        else $error("immediate extended rotate with bad amount");
    // R11
    if (!invalid && shift_kind == 3'd3 && !amt_zero)
      ror_carry_chk: assert (carry_out == result[DATA_W-1])
        else $error("rotate carry differs from result top bit");
    // R8
    if (!invalid && shift_kind == 3'd0 && amt_ge_width && shift_amount != WIDTH_AMT)
      lsl_wide_chk: assert (result == '0 && carry_out == 1'b0)
        else $error("wide left shift left bits behind");
  end

endmodule

bind sop_shifter_unit sop_shifter_checker #(
  .DATA_W(DATA_W), .AMT_W(AMT_W)
) u_chk (
  .src_sel      (src_sel),
  .value_in     (value_in),
  .carry_in     (carry_in),
  .shift_kind   (shift_kind),
  .shift_amount (shift_amount),
  .result       (result),
  .carry_out    (carry_out),
  .invalid      (invalid),
  .amt_zero     (amt_zero),
  .amt_ge_width (amt_ge_width)
);

// File: tb/sim_sop_shifter_unit.sv
`timescale 1ns/1ps
module sim_sop_shifter_unit;

  logic        clk = 1'b0;
  logic [31:0] instr_word;
  logic        layout_alt;
  logic [1:0]  src_sel;
  logic [1:0]  reg_type;
  logic [31:0] reg_value;
  logic [2:0]  direct_op;
  logic [31:0] value_in;
  logic        carry_in;
  logic [2:0]  shift_kind;
  logic [7:0]  shift_amount;
  logic [31:0] result;
  logic        carry_out;
  logic        invalid;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  sop_shifter_unit u0 (
    .instr_word(instr_word), .layout_alt(layout_alt), .src_sel(src_sel),
    .reg_type(reg_type), .reg_value(reg_value), .direct_op(direct_op),
    .value_in(value_in), .carry_in(carry_in), .shift_kind(shift_kind),
    .shift_amount(shift_amount), .result(result), .carry_out(carry_out),
    .invalid(invalid)
  );

  // Reference decode, written from the requirements.
  task automatic ref_decode(output logic [2:0] op, output logic [7:0] amt);
    int t, f;
    if (src_sel == 2'd0) begin
      if (!layout_alt) begin
        t = int'((instr_word >> 5) & 32'd3);
        f = int'((instr_word >> 7) & 32'd31);
      end else begin
        t = int'((instr_word >> 4) & 32'd3);
        f = int'(((instr_word >> 12) & 32'd7) * 4 + ((instr_word >> 6) & 32'd3));
      end
      op  = 3'(t);
      amt = 8'(f);
      if ((t == 1 || t == 2) && f == 0) amt = 8'd32;
      if (t == 3 && f == 0) begin op = 3'd4; amt = 8'd1; end
    end else if (src_sel == 2'd1) begin
      op  = {1'b0, reg_type};
      amt = 8'(reg_value % 256);
    end else begin
      op  = direct_op;
      amt = 8'(reg_value % 256);
    end
  endtask

  // Reference shift: one bit per step.
  task automatic ref_shift(input logic [2:0] op, input logic [7:0] amt,
                           output logic [31:0] r, output logic c, output logic bad);
    logic [31:0] v;
    v = value_in;
    c = carry_in;
    bad = (op > 3'd4) || (op == 3'd4 && amt != 8'd1);
    if (bad) begin r = 0; c = 0; return; end
    if (op == 3'd4) begin r = {carry_in, value_in[31:1]}; c = value_in[0]; return; end
    for (int i = 0; i < int'(amt); i++) begin
      case (op)
        3'd0: begin c = v[31]; v = {v[30:0], 1'b0}; end
        3'd1: begin c = v[0];  v = {1'b0, v[31:1]}; end
        3'd2: begin c = v[0];  v = {v[31], v[31:1]}; end
        default: begin v = {v[0], v[31:1]}; c = v[31]; end
      endcase
    end
    r = v;
  endtask

  task automatic check(input string tag);
    logic [2:0] eop; logic [7:0] eamt; logic [31:0] er; logic ec, ebad;
    bit bad_any;
    ref_decode(eop, eamt);
    ref_shift(eop, eamt, er, ec, ebad);
    checks++;
    bad_any = 0;
    if (shift_kind !== eop) begin
      $display("FAIL %s shift_kind actual=%0d expected=%0d", tag, shift_kind, eop); bad_any = 1; end
    if (shift_amount !== eamt) begin
      $display("FAIL %s shift_amount actual=%0d expected=%0d", tag, shift_amount, eamt); bad_any = 1; end
    if (result !== er) begin
      $display("FAIL %s result actual=%h expected=%h", tag, result, er); bad_any = 1; end
    if (carry_out !== ec) begin
      $display("FAIL %s carry_out actual=%b expected=%b", tag, carry_out, ec); bad_any = 1; end
    if (invalid !== ebad) begin
      $display("FAIL %s invalid actual=%b expected=%b", tag, invalid, ebad); bad_any = 1; end
    if (bad_any) errors++;
  endtask

  task automatic apply(input logic [1:0] s, input logic alt, input logic [31:0] iw,
                       input logic [1:0] rt, input logic [31:0] rv, input logic [2:0] dop,
                       input logic [31:0] v, input logic ci, input string tag);
    @(posedge clk);
    src_sel = s; layout_alt = alt; instr_word = iw; reg_type = rt;
    reg_value = rv; direct_op = dop; value_in = v; carry_in = ci;
    @(negedge clk);
    check(tag);
  endtask

  function automatic logic [31:0] instr_a(input int t, input int f);
    return (32'(t) << 5) | (32'(f) << 7) | 32'hF000_001F;
  endfunction

  function automatic logic [31:0] instr_b(input int t, input int f);
    return (32'(t) << 4) | (32'(f / 4) << 12) | (32'(f % 4) << 6) | 32'hFFF8_0F0F;
  endfunction

  function automatic string op_tag(input logic [2:0] op);
    case (op)
      3'd0: return "R8";
      3'd1: return "R9";
      3'd2: return "R10";
      3'd3: return "R11";
      3'd4: return "R12";
      default: return "R13";
    endcase
  endfunction

  initial begin
    logic [2:0] pop; logic [7:0] pamt;
    void'($urandom(32'd1234));
    src_sel = 0; layout_alt = 0; instr_word = 0; reg_type = 0;
    reg_value = 0; direct_op = 0; value_in = 0; carry_in = 0;
    @(negedge clk);
    check("R7 idle state");

    // R1 first layout
    apply(2'd0, 1'b0, instr_a(0, 13), 0, 0, 0, 32'h8000_0F01, 1'b0, "R1 layout A LSL");
    apply(2'd0, 1'b0, instr_a(2, 7),  0, 0, 0, 32'h8765_4321, 1'b1, "R1 layout A ASR");
    // R2 second layout
    apply(2'd0, 1'b1, instr_b(1, 22), 0, 0, 0, 32'hDEAD_BEEF, 1'b0, "R2 layout B LSR");
    apply(2'd0, 1'b1, instr_b(3, 9),  0, 0, 0, 32'h1234_5678, 1'b0, "R2 layout B ROR");
    // R3 zero field reinterpretation
    apply(2'd0, 1'b0, instr_a(1, 0), 0, 0, 0, 32'h8000_0000, 1'b0, "R3 LSR imm0 is 32");
    apply(2'd0, 1'b0, instr_a(2, 0), 0, 0, 0, 32'h8000_0001, 1'b0, "R3 ASR imm0 is 32");
    apply(2'd0, 1'b1, instr_b(0, 0), 0, 0, 0, 32'hCAFE_F00D, 1'b1, "R3 LSL imm0 passes");
    // R4 RRX from immediate
    apply(2'd0, 1'b0, instr_a(3, 0), 0, 0, 0, 32'h0000_0003, 1'b1, "R4 RRX imm");
    apply(2'd0, 1'b1, instr_b(3, 0), 0, 0, 0, 32'hFFFF_FFFE, 1'b0, "R4 RRX layout B");
    // R5 register source, upper bits ignored
    apply(2'd1, 1'b0, 0, 2'd3, 32'h0000_0008, 0, 32'h1234_5678, 1'b0, "R5 reg ROR 8");
    apply(2'd1, 1'b0, 0, 2'd3, 32'hFFFF_FF08, 0, 32'h1234_5678, 1'b0, "R5 reg upper bits ignored");
    apply(2'd1, 1'b0, 0, 2'd0, 32'hABCD_0000, 0, 32'h1234_5678, 1'b1, "R5 reg amount 0 upper set");
    // R6 explicit source
    apply(2'd2, 1'b0, 0, 0, 32'h0000_0001, 3'd4, 32'h0000_0001, 1'b1, "R6 explicit RRX");
    apply(2'd3, 1'b0, 0, 0, 32'h0000_0005, 3'd1, 32'hF000_0000, 1'b0, "R6 explicit LSR");
    // R7 zero amount
    apply(2'd1, 1'b0, 0, 2'd2, 32'h0, 0, 32'h8000_0000, 1'b1, "R7 ASR by 0");
    // R8 LSL edges
    apply(2'd1, 1'b0, 0, 2'd0, 32'd32,  0, 32'h0000_0001, 1'b0, "R8 LSL 32");
    apply(2'd1, 1'b0, 0, 2'd0, 32'd33,  0, 32'hFFFF_FFFF, 1'b1, "R8 LSL 33");
    apply(2'd1, 1'b0, 0, 2'd0, 32'd255, 0, 32'hFFFF_FFFF, 1'b1, "R8 LSL 255");
    // R9 LSR edges
    apply(2'd1, 1'b0, 0, 2'd1, 32'd32, 0, 32'h8000_0000, 1'b0, "R9 LSR 32");
    apply(2'd1, 1'b0, 0, 2'd1, 32'd40, 0, 32'hFFFF_FFFF, 1'b1, "R9 LSR 40");
    // R10 ASR edges
    apply(2'd1, 1'b0, 0, 2'd2, 32'd100, 0, 32'h8000_0000, 1'b0, "R10 ASR 100 neg");
    apply(2'd1, 1'b0, 0, 2'd2, 32'd200, 0, 32'h7FFF_FFFF, 1'b1, "R10 ASR 200 pos");
    apply(2'd1, 1'b0, 0, 2'd2, 32'd31,  0, 32'hC000_0000, 1'b0, "R10 ASR 31");
    // R11 rotate wrap
    apply(2'd1, 1'b0, 0, 2'd3, 32'd32, 0, 32'h8000_0001, 1'b0, "R11 ROR 32");
    apply(2'd1, 1'b0, 0, 2'd3, 32'd65, 0, 32'h0000_0001, 1'b0, "R11 ROR 65");
    // R12 RRX
    apply(2'd2, 1'b0, 0, 0, 32'd1, 3'd4, 32'hAAAA_AAAA, 1'b0, "R12 RRX ci0");
    // R13 invalid requests
    apply(2'd2, 1'b0, 0, 0, 32'd0, 3'd4, 32'h1234_5678, 1'b1, "R13 RRX amount 0");
    apply(2'd2, 1'b0, 0, 0, 32'd2, 3'd4, 32'h1234_5678, 1'b1, "R13 RRX amount 2");
    apply(2'd3, 1'b0, 0, 0, 32'd3, 3'd6, 32'hFFFF_FFFF, 1'b1, "R13 reserved op");

    // Constrained random mix
    for (int n = 0; n < 600; n++) begin
      logic [1:0] s; logic [31:0] rv; logic [2:0] dop;
      s   = 2'($urandom_range(0, 3));
      rv  = $urandom;
      if ($urandom_range(0, 3) == 0) rv[7:0] = 8'($urandom_range(0, 40));
      dop = ($urandom_range(0, 7) == 0) ? 3'($urandom_range(5, 7)) : 3'($urandom_range(0, 4));
      @(posedge clk);
      src_sel = s; layout_alt = 1'($urandom_range(0, 1)); instr_word = $urandom;
      reg_type = 2'($urandom_range(0, 3)); reg_value = rv; direct_op = dop;
      value_in = $urandom; carry_in = 1'($urandom_range(0, 1));
      @(negedge clk);
      ref_decode(pop, pamt);
      check({op_tag(pop), " random"});
    end

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule